// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo PCM from a three-wire serial audio link: a bit clock, a frame clock and one data line. It runs on a system clock that is much faster than the bit clock. The three link wires are brought into the system clock domain, and the block finds bit-clock rising edges there. From those edges it counts bit slots inside each half of the frame. It then picks out the data bits of the left word and the right word. The bit clock runs at 64 times the sample rate, so each channel half holds 32 slots.

The framing can be chosen at run time: I2S, left-justified or right-justified. The word length can be 16, 20 or 24 bits. Slots outside the word's window are ignored. Each finished word is sign-extended to 24 bits. When a frame's right word is finished, the left and right samples are written to the outputs together and a one-cycle valid strobe is raised. A change of format or word length is not applied in the middle of a frame. It waits until the frame clock starts a new left half.

Top module: `pcm_serial_rx`

## Requirements
- R1: Bit clock, frame clock and data each pass through two synchroniser flip-flops. A data bit is taken only on a rising edge of the bit clock, and words are assembled MSB first.
- R2: Slot 0 is the first bit-clock rise after a frame-clock change. Each later rise adds one, up to slot 31. Further rises without a frame-clock change capture nothing and produce no output. Capture is also off after reset until the first frame-clock change.
- R3: With format code 0 (code 3 behaves the same), I2S framing applies. A low frame clock marks the left half, and word bit W-1 sits in slot 1, so the word fills slots 1..W.
- R4: With format code 1, left-justified framing applies. A high frame clock marks the left half, and the word fills slots 0..W-1.
- R5: With format code 2, right-justified framing applies. A high frame clock marks the left half, and the word fills slots 32-W..31, with the LSB in slot 31.
- R6: Word-length code 0 selects W=16, code 1 selects W=20, and codes 2 and 3 select W=24.
- R7: Data in slots outside the selected word window has no effect on the output samples.
- R8: Each output sample is the received W-bit word sign-extended to 24 bits.
- R9: valid_o is high for exactly one system clock when a right word finishes and a left word has finished since the last strobe. left_o and right_o change in that same cycle and hold their values otherwise.
- R10: Requested format and length become active at the next frame-clock change that starts a left half under the active format. A frame already in progress finishes under the old settings.
- R11: Reset clears left_o, right_o and valid_o, and selects I2S with 24-bit words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Serial bit clock |
| lrck_i | input | 1 | Frame (channel select) clock |
| sdat_i | input | 1 | Serial data line |
| fmt_i | input | 2 | Requested framing: 0 I2S, 1 left-justified, 2 right-justified, 3 as 0 |
| wlen_i | input | 2 | Requested word length: 0 = 16, 1 = 20, 2/3 = 24 bits |
| left_o | output | 24 | Left sample, sign-extended |
| right_o | output | 24 | Right sample, sign-extended |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
Two events can fall on the same bit-clock rise. One is the frame-clock change that makes a newly requested format and length active. The other is the capture of slot 0, which in left-justified mode already carries the MSB. That rise must be decoded with the new settings. The stimulus table switches format and word length between its entries, each with a different channel polarity and word window. The bench judges the result by requiring the second frame after each switch to decode exactly, and by requiring the first frame after reset to produce no strobe. A second collision comes from changing the word length in the middle of a left half. That frame must still decode at the old length, and the next frame at the new one.

// File: rtl/pcm_rx_pkg.sv
`timescale 1ns/1ps
package pcm_rx_pkg;

   typedef enum logic [1:0] {
      FMT_I2S    = 2'd0,
      FMT_LEFTJ  = 2'd1,
      FMT_RIGHTJ = 2'd2,
      FMT_ALT    = 2'd3
   } frame_fmt_e;

   typedef enum logic [1:0] {
      WL_16  = 2'd0,
      WL_20  = 2'd1,
      WL_24  = 2'd2,
      WL_24B = 2'd3
   } word_len_e;

   localparam int WBITS_W = 5;

   function automatic int word_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 16;
         2'd1:    return 20;
         default: return 24;
      endcase
   endfunction

   // frame-clock level that marks the left half for a framing code
   function automatic logic left_level(input logic [1:0] fmt);
      return (fmt == FMT_LEFTJ) || (fmt == FMT_RIGHTJ);
   endfunction

endpackage

// File: rtl/pcm_link_sync.sv
`timescale 1ns/1ps
module pcm_link_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_i,
   input  logic lrck_i,
   input  logic sdat_i,
   output logic bclk_rise,
   output logic lrck_s,
   output logic sdat_s
);
   localparam int NSIG = 3;

   logic [STAGES-1:0][NSIG-1:0] stage_q;
   logic                        bclk_last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q     <= '0;
         bclk_last_q <= 1'b0;
      end else begin
         stage_q[0] <= {sdat_i, lrck_i, bclk_i};
         for (int i = 1; i < STAGES; i++) begin
            stage_q[i] <= stage_q[i-1];
         end
         bclk_last_q <= stage_q[STAGES-1][0];
      end
   end

   assign bclk_rise = stage_q[STAGES-1][0] & ~bclk_last_q;
   assign lrck_s    = stage_q[STAGES-1][1];
   assign sdat_s    = stage_q[STAGES-1][2];

endmodule

// File: rtl/pcm_frame_track.sv
`timescale 1ns/1ps
module pcm_frame_track import pcm_rx_pkg::*; #(
   parameter int SLOTS  = 32,
   parameter int SLOT_W = $clog2(SLOTS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_rise,
   input  logic               lrck_s,
   input  logic [1:0]         fmt_req,
   input  logic [1:0]         wlen_req,
   output logic               lr_edge,
   output logic               take_bit,
   output logic               last_bit,
   output logic               is_left,
   output logic [1:0]         act_fmt,
   output logic [1:0]         act_wlen,
   output logic [WBITS_W-1:0] wbits
);
   logic              lrck_prev_q;
   logic              live_q;
   logic              live_now;
   logic [SLOT_W-1:0] slot_q;
   logic [SLOT_W-1:0] slot_now;
   logic [1:0]        fmt_q;
   logic [1:0]        wlen_q;
   logic [1:0]        fmt_now;
   logic [1:0]        wlen_now;
   logic              in_win;
   logic              at_end;
   int                wb;
   int                sl;

   always_comb begin
      lr_edge  = bit_rise && (lrck_s != lrck_prev_q);
      fmt_now  = fmt_q;
      wlen_now = wlen_q;
      if (lr_edge && (lrck_s == left_level(fmt_q))) begin
         fmt_now  = fmt_req;
         wlen_now = wlen_req;
      end
      if (lr_edge) begin
         slot_now = '0;
         live_now = 1'b1;
      end else if (slot_q == SLOT_W'(SLOTS-1)) begin
         slot_now = slot_q;
         live_now = 1'b0;
      end else begin
         slot_now = slot_q + 1'b1;
         live_now = live_q;
      end
      wb = word_bits(wlen_now);
      sl = 32'(slot_now);
      case (fmt_now)
         FMT_LEFTJ: begin
            in_win = sl < wb;
            at_end = sl == wb - 1;
         end
         FMT_RIGHTJ: begin
            in_win = sl >= SLOTS - wb;
            at_end = sl == SLOTS - 1;
         end
         default: begin
            in_win = (sl >= 1) && (sl <= wb);
            at_end = sl == wb;
         end
      endcase
      take_bit = bit_rise && live_now && in_win;
      last_bit = take_bit && at_end;
      is_left  = (lrck_s == left_level(fmt_now));
      wbits    = WBITS_W'(wb);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lrck_prev_q <= 1'b0;
         slot_q      <= SLOT_W'(SLOTS-1);
         live_q      <= 1'b0;
         fmt_q       <= FMT_I2S;
         wlen_q      <= WL_24;
      end else if (bit_rise) begin
         lrck_prev_q <= lrck_s;
         slot_q      <= slot_now;
         live_q      <= live_now;
         fmt_q       <= fmt_now;
         wlen_q      <= wlen_now;
      end
   end

   assign act_fmt  = fmt_q;
   assign act_wlen = wlen_q;

endmodule

// File: rtl/pcm_word_shift.sv
`timescale 1ns/1ps
module pcm_word_shift import pcm_rx_pkg::*; #(
   parameter int OUT_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_en,
   input  logic               bit_in,
   input  logic [WBITS_W-1:0] wbits,
   output logic [OUT_W-1:0]   word
);
   logic [OUT_W-1:0] sh_q;
   logic [OUT_W-1:0] cand;
   logic             sgn;

   assign cand = {sh_q[OUT_W-2:0], bit_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (shift_en) begin
         sh_q <= cand;
      end
   end

   always_comb begin
      sgn  = cand[wbits - 1'b1];
      word = cand;
      for (int i = 0; i < OUT_W; i++) begin
         if (i >= int'(wbits)) begin
            word[i] = sgn;
         end
      end
   end

endmodule

// File: rtl/pcm_serial_rx.sv
`timescale 1ns/1ps
module pcm_serial_rx import pcm_rx_pkg::*; #(
   parameter int SYNC_STAGES  = 2,
   parameter int SLOTS_PER_CH = 32,
   parameter int OUT_W        = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bclk_i,
   input  logic             lrck_i,
   input  logic             sdat_i,
   input  logic [1:0]       fmt_i,
   input  logic [1:0]       wlen_i,
   output logic [OUT_W-1:0] left_o,
   output logic [OUT_W-1:0] right_o,
   output logic             valid_o
);
   localparam int NCH    = 2;
   localparam int SLOT_W = $clog2(SLOTS_PER_CH);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pcm_serial_rx: SYNC_STAGES must be at least 2");
   end
   if (OUT_W < 24) begin : g_bad_width
      $error("pcm_serial_rx: OUT_W must hold a 24-bit word");
   end
   if (SLOTS_PER_CH < OUT_W + 1) begin : g_bad_slots
      $error("pcm_serial_rx: too few slots per channel for the word length");
   end

   logic               bit_rise;
   logic               lrck_s;
   logic               sdat_s;
   logic               lr_edge;
   logic               take_bit;
   logic               last_bit;
   logic               is_left;
   logic [1:0]         act_fmt;
   logic [1:0]         act_wlen;
   logic [WBITS_W-1:0] wbits;
   logic [NCH-1:0]     ch_en;
   logic [OUT_W-1:0]   ch_word [NCH];
   logic [OUT_W-1:0]   left_hold_q;
   logic               left_ok_q;

   pcm_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .bclk_i    (bclk_i),
      .lrck_i    (lrck_i),
      .sdat_i    (sdat_i),
      .bclk_rise (bit_rise),
      .lrck_s    (lrck_s),
      .sdat_s    (sdat_s)
   );

   pcm_frame_track #(.SLOTS(SLOTS_PER_CH), .SLOT_W(SLOT_W)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_rise (bit_rise),
      .lrck_s   (lrck_s),
      .fmt_req  (fmt_i),
      .wlen_req (wlen_i),
      .lr_edge  (lr_edge),
      .take_bit (take_bit),
      .last_bit (last_bit),
      .is_left  (is_left),
      .act_fmt  (act_fmt),
      .act_wlen (act_wlen),
      .wbits    (wbits)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      assign ch_en[c] = take_bit && (is_left == (c == 0));
      pcm_word_shift #(.OUT_W(OUT_W)) u_shift (
         .clk      (clk),
         .rst_n    (rst_n),
         .shift_en (ch_en[c]),
         .bit_in   (sdat_s),
         .wbits    (wbits),
         .word     (ch_word[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_hold_q <= '0;
         left_ok_q   <= 1'b0;
         left_o      <= '0;
         right_o     <= '0;
         valid_o     <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (last_bit && is_left) begin
            left_hold_q <= ch_word[0];
            left_ok_q   <= 1'b1;
         end else if (last_bit && left_ok_q) begin
            left_o    <= left_hold_q;
            right_o   <= ch_word[1];
            valid_o   <= 1'b1;
            left_ok_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pcm_serial_rx_chk.sv
`timescale 1ns/1ps
module pcm_serial_rx_chk import pcm_rx_pkg::*; #(
   parameter int OUT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             valid_o,
   input logic [OUT_W-1:0] left_o,
   input logic [OUT_W-1:0] right_o,
   input logic [1:0]       act_fmt,
   input logic [1:0]       act_wlen,
   input logic             lr_edge
);
   function automatic logic ext_ok(input logic [OUT_W-1:0] v, input logic [1:0] wl);
      int w;
      w = word_bits(wl);
      for (int i = 0; i < OUT_W; i++) begin
         if (i >= w - 1 && v[i] != v[w-1]) return 1'b0;
      end
      return 1'b1;
   endfunction

   AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o); // R9

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(left_o) && $stable(right_o))); // R9

   AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (ext_ok(left_o, act_wlen) && ext_ok(right_o, act_wlen))); // R8

   AST_SETTING_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      ((act_fmt != $past(act_fmt)) || (act_wlen != $past(act_wlen))) |-> $past(lr_edge)); // R10

endmodule

bind pcm_serial_rx pcm_serial_rx_chk #(.OUT_W(OUT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .valid_o  (valid_o),
   .left_o   (left_o),
   .right_o  (right_o),
   .act_fmt  (act_fmt),
   .act_wlen (act_wlen),
   .lr_edge  (lr_edge)
);

// File: tb/sim_pcm_serial_rx.sv
`timescale 1ns/1ps
module sim_pcm_serial_rx;
   localparam int HB = 4;
   localparam int NV = 10;
   // {fmt[1:0], wlen[1:0], fill, left[23:0], right[23:0]}
   localparam logic [52:0] VEC [NV] = '{
      {2'd1, 2'd2, 1'b0, 24'h123456, 24'hABCDEF},
      {2'd1, 2'd0, 1'b1, 24'h008001, 24'h007FFE},
      {2'd1, 2'd1, 1'b1, 24'h080000, 24'h012345},
      {2'd0, 2'd2, 1'b1, 24'h800000, 24'h7FFFFF},
      {2'd0, 2'd0, 1'b0, 24'h001234, 24'h00FEDC},
      {2'd0, 2'd1, 1'b1, 24'h0FFFFF, 24'h000001},
      {2'd2, 2'd2, 1'b0, 24'h5A5A5A, 24'hA5A5A5},
      {2'd2, 2'd0, 1'b1, 24'h004321, 24'h008765},
      {2'd2, 2'd1, 1'b1, 24'h07FFFF, 24'h080001},
      {2'd1, 2'd3, 1'b1, 24'hC00003, 24'h3FFFFC}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b0;
   logic        lrck = 1'b0;
   logic        sdat = 1'b0;
   logic [1:0]  fmt = 2'd0;
   logic [1:0]  wlen = 2'd2;
   logic [23:0] left_o;
   logic [23:0] right_o;
   logic        valid_o;
   int          total = 0;
   int          bad = 0;
   int          vcnt = 0;
   logic [23:0] got_l = '0;
   logic [23:0] got_r = '0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   pcm_serial_rx u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .bclk_i  (bclk),
      .lrck_i  (lrck),
      .sdat_i  (sdat),
      .fmt_i   (fmt),
      .wlen_i  (wlen),
      .left_o  (left_o),
      .right_o (right_o),
      .valid_o (valid_o)
   );

   always @(negedge clk) begin
      if (valid_o) begin
         vcnt++;
         got_l = left_o;
         got_r = right_o;
      end
   end

   function automatic int wb(input logic [1:0] c);
      return (c == 2'd0) ? 16 : ((c == 2'd1) ? 20 : 24);
   endfunction

   function automatic logic [23:0] sext(input logic [23:0] v, input int w);
      logic [23:0] m;
      logic [23:0] x;
      m = (24'h1 << w) - 24'h1;
      x = v & m;
      if (x[w-1]) x = x | ~m;
      return x;
   endfunction

   task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put_slot(input logic lv, input logic d);
      @(negedge clk);
      bclk = 1'b0;
      lrck = lv;
      sdat = d;
      repeat (HB-1) @(negedge clk);
      bclk = 1'b1;
      repeat (HB) @(negedge clk);
   endtask

   task automatic send_frame(input logic [1:0] f, input logic [1:0] wc,
                             input logic [23:0] lw, input logic [23:0] rw,
                             input logic fill, input int sw_slot, input logic [1:0] sw_w);
      int          w;
      logic        lft;
      logic [23:0] word;
      logic        lv;
      logic        d;
      w   = wb(wc);
      lft = (f == 2'd1) || (f == 2'd2);
      for (int h = 0; h < 2; h++) begin
         word = (h == 0) ? lw : rw;
         lv   = (h == 0) ? lft : ~lft;
         for (int s = 0; s < 32; s++) begin
            d = fill;
            if (f == 2'd1) begin
               if (s < w) d = word[w-1-s];
            end else if (f == 2'd2) begin
               if (s >= 32 - w) d = word[31-s];
            end else begin
               if (s >= 1 && s <= w) d = word[w-s];
            end
            if (h == 0 && s == sw_slot) wlen = sw_w;
            put_slot(lv, d);
         end
      end
      @(negedge clk);
      bclk = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   initial begin
      int          v0;
      logic [1:0]  f;
      logic [1:0]  wc;
      logic        fill;
      logic [23:0] lw;
      logic [23:0] rw;
      string       tg;

      repeat (5) @(negedge clk);
      chk("R11 reset left_o", left_o, 24'h0);
      chk("R11 reset right_o", right_o, 24'h0);
      chk("R11 reset valid_o", {23'h0, valid_o}, 24'h0);
      rst_n = 1'b1;
      fmt   = 2'd1;
      wlen  = 2'd2;
      repeat (3) @(negedge clk);

      // R10 R9: reset leaves I2S active, so the first left-justified frame yields nothing
      v0 = vcnt;
      send_frame(2'd1, 2'd2, 24'h111111, 24'h222222, 1'b0, -1, 2'd0);
      chk("R10 R9 no strobe in first frame after reset", 24'(vcnt - v0), 24'h0);

      for (int i = 0; i < NV; i++) begin
         f    = VEC[i][52:51];
         wc   = VEC[i][50:49];
         fill = VEC[i][48];
         lw   = VEC[i][47:24];
         rw   = VEC[i][23:0];
         tg   = (f == 2'd1) ? "R4" : ((f == 2'd2) ? "R5" : "R3");
         fmt  = f;
         wlen = wc;
         send_frame(f, wc, lw, rw, fill, -1, 2'd0);
         v0 = vcnt;
         send_frame(f, wc, lw, rw, fill, -1, 2'd0);
         chk($sformatf("%s R1 R6 R7 R8 left vec%0d", tg, i), got_l, sext(lw, wb(wc)));
         chk($sformatf("%s R1 R6 R7 R8 right vec%0d", tg, i), got_r, sext(rw, wb(wc)));
         chk($sformatf("R9 one strobe per frame vec%0d", i), 24'(vcnt - v0), 24'h1);
      end

      // R10: length change in mid-frame keeps the old length for that frame
      fmt  = 2'd1;
      wlen = 2'd2;
      send_frame(2'd1, 2'd2, 24'h654321, 24'h9ABCDE, 1'b1, 5, 2'd0);
      chk("R10 mid-frame change left", got_l, 24'h654321);
      chk("R10 mid-frame change right", got_r, 24'h9ABCDE);
      send_frame(2'd1, 2'd0, 24'h00F00F, 24'h0000FF, 1'b1, -1, 2'd0);
      chk("R10 new length next frame left", got_l, 24'hFFF00F);
      chk("R10 new length next frame right", got_r, 24'h0000FF);

      // R2 R9: extra bit-clock rises without a frame-clock change do nothing
      v0 = vcnt;
      for (int k = 0; k < 40; k++) put_slot(1'b0, k[0]);
      @(negedge clk);
      bclk = 1'b0;
      repeat (8) @(negedge clk);
      chk("R2 no strobe after slot 31", 24'(vcnt - v0), 24'h0);
      chk("R9 left_o holds", left_o, 24'hFFF00F);
      chk("R9 right_o holds", right_o, 24'h0000FF);
      send_frame(2'd1, 2'd0, 24'h00ABCD, 24'h001357, 1'b0, -1, 2'd0);
      chk("R2 recovery left", got_l, 24'hFFABCD);
      chk("R2 recovery right", got_r, 24'h001357);

      // R11: reset while running
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R11 mid-run reset left_o", left_o, 24'h0);
      chk("R11 mid-run reset right_o", right_o, 24'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule